// File: doc/BRIEF.md
# Single-Wire Bus Bit Slot Engine

This block is the bit-level master for a single-wire, open-drain serial bus. One command runs one bit time slot: write a one, write a zero, or read one bit from a device on the bus. The master only ever pulls the wire low through an output-enable. The rest of the time it releases the wire, and an external resistor raises it. The returning wire level passes through a synchroniser before the engine uses it.

All slot durations are whole microseconds, counted by an internal tick. The tick prescaler restarts on every accepted command, so a microsecond is exactly `CLK_PER_US` clock cycles measured from acceptance. The six timing values are inputs and are captured when a command is taken. A read is resolved by timing: the engine measures when the device lets the wire go high, against a read-valid deadline. It does not take one sample at a fixed point. Every slot, of any kind, is padded out to the full slot time plus recovery time before the engine reports completion.

Top module: `owb_slot_engine`

## Requirements
- R1: After reset the wire is released, `done` and `rd_bit` are 0 and `cmd_ready` is 1. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high, and `line_oe` is high from the next cycle.
- R2: With `cmd_op` = 2'b01 (write one), `line_oe` stays high for exactly `t_low1`×`CLK_PER_US` cycles from the cycle after acceptance.
- R3: With `cmd_op` = 2'b00 (write zero), `line_oe` stays high for exactly `t_low0`×`CLK_PER_US` cycles.
- R4: `done` rises `T`×`CLK_PER_US` cycles after the accepting edge. For writes, `T` = max(low time, `t_slot`+`t_rec`). For reads, `T` = `t_slot`+`t_rec` when the read decision comes earlier. `cmd_ready` is high again in that same cycle.
- R5: With `cmd_op[1]` = 1 (2'b10 or 2'b11, read), `line_oe` stays high for exactly `t_lowr`×`CLK_PER_US` cycles.
- R6: The wire passes through a two-flop synchroniser. In a read, the engine ends its watch at the first high synchronised level, or once the elapsed whole-microsecond count reaches `t_rdv`+2. The bit is 1 only if the wire is seen high while the elapsed count is below `t_rdv`. Otherwise the bit is 0, and a wire held low is also read as 0.
- R7: While the engine is busy, `cmd_valid` and `cmd_op` have no effect. `line_oe` does not rise again and exactly one `done` occurs per accepted command.
- R8: `done` is a single-cycle pulse. `rd_bit` carries the read result alongside it and is 0 on the completion of a write slot.
- R9: All timing inputs are captured at acceptance. Changing them during a slot does not change that slot's low time or length.
- R10: `line_oe` is only ever high while a slot is in progress (`cmd_ready` low).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 2 | 00 write zero, 01 write one, 1x read |
| t_low1 | input | TW | Low time for a one, microseconds |
| t_low0 | input | TW | Low time for a zero, microseconds |
| t_lowr | input | TW | Low time opening a read slot, microseconds |
| t_rdv | input | TW | Read-valid deadline from slot start, microseconds |
| t_slot | input | TW | Slot time, microseconds |
| t_rec | input | TW | Recovery time, microseconds |
| line_in | input | 1 | Wire level, asynchronous |
| line_oe | output | 1 | Pull wire low when high |
| done | output | 1 | One-cycle slot completion |
| rd_bit | output | 1 | Read result, valid with done |

## Verification
A wrong microsecond or state count shows up at the ports as a low pulse or slot length that misses its exact cycle count. The bench catches it on the first slot it affects, because it counts each pulse to the cycle. A wrong read decision, such as an off-by-one against the deadline or a missing synchroniser stage, flips `rd_bit` only when the device releases the wire close to a microsecond boundary. For that reason the bench sweeps the release time one cycle at a time across the whole window. A stuck or re-entered state appears as an extra output-enable pulse or a second `done` within the same slot.

// File: rtl/owb_pkg.sv
package owb_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOW   = 2'd1,
      ST_WATCH = 2'd2,
      ST_REL   = 2'd3
   } owb_state_e;

   localparam logic [1:0] OP_WR0 = 2'b00;
   localparam logic [1:0] OP_WR1 = 2'b01;
endpackage

// File: rtl/owb_tick_gen.sv
module owb_tick_gen #(
   parameter int CLK_PER_US = 50
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   output logic tick
);
   localparam int CW = (CLK_PER_US > 2) ? $clog2(CLK_PER_US) : 1;
   localparam logic [CW-1:0] LAST = CW'(CLK_PER_US - 1);

   if (CLK_PER_US < 2) begin : g_bad_div
      $error("owb_tick_gen: CLK_PER_US must be at least 2");
   end

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (clear)       cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == LAST);
endmodule

// File: rtl/owb_line_sync.sv
module owb_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("owb_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= 1'b1;
         else if (i == 0) chain[i] <= din;
         else chain[i] <= chain[(i > 0) ? i - 1 : 0];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/owb_slot_fsm.sv
module owb_slot_fsm
   import owb_pkg::*;
#(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          line_s,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_op,
   input  logic [TW-1:0] t_low1,
   input  logic [TW-1:0] t_low0,
   input  logic [TW-1:0] t_lowr,
   input  logic [TW-1:0] t_rdv,
   input  logic [TW-1:0] t_slot,
   input  logic [TW-1:0] t_rec,
   output logic          accept,
   output logic          idle,
   output logic          oe,
   output logic          done,
   output logic          bit_out
);
   localparam int UW = TW + 2;
   localparam logic [UW-1:0] UMAX = {UW{1'b1}};

   owb_state_e    state;
   logic          is_rd;
   logic [UW-1:0] us, us_nxt;
   logic [UW-1:0] low_q, rdv_q, lim_q, total_q;
   logic [TW-1:0] low_sel;

   assign idle   = (state == ST_IDLE);
   assign accept = idle && cmd_valid;
   assign us_nxt = (us == UMAX) ? us : us + 1'b1;

   always_comb begin
      if (cmd_op[1])            low_sel = t_lowr;
      else if (cmd_op == OP_WR1) low_sel = t_low1;
      else                      low_sel = t_low0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         is_rd   <= 1'b0;
         us      <= '0;
         low_q   <= '0;
         rdv_q   <= '0;
         lim_q   <= '0;
         total_q <= '0;
         oe      <= 1'b0;
         done    <= 1'b0;
         bit_out <= 1'b0;
      end else begin
         done <= 1'b0;
         if (tick && !idle) us <= us_nxt;
         unique case (state)
            ST_IDLE: begin
               if (cmd_valid) begin
                  is_rd   <= cmd_op[1];
                  low_q   <= UW'(low_sel);
                  rdv_q   <= UW'(t_rdv);
                  lim_q   <= UW'(t_rdv) + UW'(2);
                  total_q <= UW'(t_slot) + UW'(t_rec);
                  us      <= '0;
                  oe      <= 1'b1;
                  bit_out <= 1'b0;
                  state   <= ST_LOW;
               end
            end
            ST_LOW: begin
               if (tick && us_nxt >= low_q) begin
                  oe <= 1'b0;
                  if (is_rd) state <= ST_WATCH;
                  else if (us_nxt >= total_q) begin
                     state <= ST_IDLE;
                     done  <= 1'b1;
                  end else state <= ST_REL;
               end
            end
            ST_WATCH: begin
               if (line_s) begin
                  bit_out <= (us < rdv_q);
                  state   <= ST_REL;
               end else if (us >= lim_q) begin
                  bit_out <= 1'b0;
                  state   <= ST_REL;
               end
            end
            ST_REL: begin
               if ((tick && us_nxt >= total_q) || us >= total_q) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/owb_slot_engine.sv
module owb_slot_engine #(
   parameter int CLK_PER_US  = 50,
   parameter int TW          = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cmd_valid,
   output logic          cmd_ready,
   input  logic [1:0]    cmd_op,
   input  logic [TW-1:0] t_low1,
   input  logic [TW-1:0] t_low0,
   input  logic [TW-1:0] t_lowr,
   input  logic [TW-1:0] t_rdv,
   input  logic [TW-1:0] t_slot,
   input  logic [TW-1:0] t_rec,
   input  logic          line_in,
   output logic          line_oe,
   output logic          done,
   output logic          rd_bit
);
   if (TW < 2) begin : g_bad_tw
      $error("owb_slot_engine: TW must be at least 2");
   end

   logic tick, line_s, accept, idle;

   owb_tick_gen #(.CLK_PER_US(CLK_PER_US)) u_tick (
      .clk(clk), .rst_n(rst_n), .clear(accept), .tick(tick)
   );

   owb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .din(line_in), .dout(line_s)
   );

   owb_slot_fsm #(.TW(TW)) u_fsm (
      .clk(clk), .rst_n(rst_n), .tick(tick), .line_s(line_s),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .t_low1(t_low1), .t_low0(t_low0), .t_lowr(t_lowr),
      .t_rdv(t_rdv), .t_slot(t_slot), .t_rec(t_rec),
      .accept(accept), .idle(idle), .oe(line_oe),
      .done(done), .bit_out(rd_bit)
   );

   assign cmd_ready = idle;
endmodule

// File: rtl/owb_slot_checker.sv
module owb_slot_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [1:0] cmd_op,
   input logic       line_oe,
   input logic       done,
   input logic       rd_bit
);
   logic rd_cmd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_cmd <= 1'b0;
      else if (cmd_valid && cmd_ready) rd_cmd <= cmd_op[1];
   end

   assert_oe_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      line_oe |-> !cmd_ready);

   assert_start_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> (line_oe && !cmd_ready));

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   assert_write_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_cmd) |-> !rd_bit);

   assert_oe_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_oe) |-> $past(cmd_valid && cmd_ready));

   assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_ready) |-> $past(cmd_valid));
endmodule

bind owb_slot_engine owb_slot_checker u_owb_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
   .cmd_op(cmd_op), .line_oe(line_oe), .done(done), .rd_bit(rd_bit)
);

// File: tb/test_owb_slot_engine.sv
module test_owb_slot_engine;
   localparam int CPU = 3;
   localparam int TW  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [TW-1:0] t_low1 = 1, t_low0 = 4, t_lowr = 1, t_rdv = 4, t_slot = 12, t_rec = 2;
   logic slave_low = 1'b0;
   logic cmd_ready, line_oe, done, rd_bit, line_in;
   int n_chk = 0, n_fail = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   assign line_in = ~(line_oe | slave_low);

   owb_slot_engine #(.CLK_PER_US(CPU), .TW(TW), .SYNC_STAGES(2)) i_owb_slot_engine (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .t_low1(t_low1), .t_low0(t_low0), .t_lowr(t_lowr),
      .t_rdv(t_rdv), .t_slot(t_slot), .t_rec(t_rec), .line_in(line_in),
      .line_oe(line_oe), .done(done), .rd_bit(rd_bit)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // hold < 0: device keeps the wire low for the whole slot
   task automatic run_slot(input int op, input int tl1, input int tl0, input int tlr,
                           input int rdv, input int slot, input int rec, input int hold,
                           input bit perturb, input bit noise);
      int lowd, total, exp_done, exp_bit, h, oe_cyc, done_idx, done_cnt, got_bit, relaunch;
      bit prev_oe;
      string rq;
      lowd  = (op >= 2) ? tlr : (op == 1) ? tl1 : tl0;
      total = slot + rec;
      exp_done = ((op < 2 && lowd > total) ? lowd : total) * CPU;
      if (op < 2 || hold < 0) exp_bit = 0;
      else begin
         h = (hold - 1 > tlr * CPU) ? hold - 1 : tlr * CPU;
         exp_bit = (((h + 2) / CPU) < rdv) ? 1 : 0;
      end
      oe_cyc = 0; done_idx = -1; done_cnt = 0; got_bit = 0; relaunch = 0; prev_oe = 1'b0;
      @(negedge clk);
      cmd_op = 2'(op); t_low1 = TW'(tl1); t_low0 = TW'(tl0); t_lowr = TW'(tlr);
      t_rdv = TW'(rdv); t_slot = TW'(slot); t_rec = TW'(rec);
      slave_low = (op >= 2) && (hold != 0);
      cmd_valid = 1'b1;
      check(cmd_ready == 1'b1, "R1", "ready before command", int'(cmd_ready), 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      for (int idx = 0; idx <= exp_done + 2; idx++) begin
         if (idx > 0) @(negedge clk);
         if (line_oe) oe_cyc++;
         if (line_oe && idx > 0 && !prev_oe) relaunch++;
         prev_oe = line_oe;
         if (done) begin
            done_cnt++;
            if (done_cnt == 1) begin
               done_idx = idx;
               got_bit  = int'(rd_bit);
            end
         end
         slave_low = (op >= 2) && (hold < 0 || idx + 1 < hold);
         if (perturb && idx == 1) begin
            t_low1 = 1; t_low0 = 1; t_lowr = 1; t_rdv = 1; t_slot = 2; t_rec = 1;
         end
         if (noise && idx == 2) begin
            cmd_valid = 1'b1;
            cmd_op = (op == 1) ? 2'b00 : 2'b01;
         end
         if (noise && idx == exp_done - 3) cmd_valid = 1'b0;
      end
      cmd_valid = 1'b0;
      slave_low = 1'b0;
      rq = (op >= 2) ? "R5" : (op == 1) ? "R2" : "R3";
      if (perturb) rq = "R9";
      check(oe_cyc == lowd * CPU, rq, "low pulse cycles", oe_cyc, lowd * CPU);
      check(done_idx == exp_done, perturb ? "R9" : "R4", "done cycle", done_idx, exp_done);
      check(done_cnt == 1, noise ? "R7" : "R8", "done pulses", done_cnt, 1);
      check(got_bit == exp_bit, (op >= 2) ? "R6" : "R8", "bit with done", got_bit, exp_bit);
      check(relaunch == 0, "R7", "extra low pulses", relaunch, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      check(1'b0, "watchdog", "run completed", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(line_oe == 1'b0, "R1", "oe in reset", int'(line_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(line_oe == 1'b0, "R1", "oe after reset", int'(line_oe), 0);
      check(done == 1'b0, "R1", "done after reset", int'(done), 0);
      check(rd_bit == 1'b0, "R1", "bit after reset", int'(rd_bit), 0);
      check(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);

      // R2 R3 R4: write slot sweep
      for (int op = 0; op < 2; op++)
         for (int tl = 1; tl <= 4; tl++)
            for (int s = 6; s <= 8; s += 2)
               for (int rc = 1; rc <= 3; rc += 2)
                  run_slot(op, tl, tl, 1, 4, s, rc, 0, 1'b0, 1'b0);

      // R4: low time longer than slot plus recovery
      run_slot(1, 5, 1, 1, 4, 2, 1, 0, 1'b0, 1'b0);
      run_slot(0, 1, 6, 1, 4, 3, 1, 0, 1'b0, 1'b0);

      // R5 R6: read sweep over release cycle, both read encodings
      for (int tlr = 1; tlr <= 3; tlr++)
         for (int rdv = 4; rdv <= 6; rdv += 2) begin
            run_slot(2, 1, 1, tlr, rdv, 12, 2, -1, 1'b0, 1'b0);
            for (int hold = 0; hold <= (rdv + 3) * CPU; hold++)
               run_slot(((hold % 2) == 0) ? 2 : 3, 1, 1, tlr, rdv, 12, 2, hold,
                        1'b0, 1'b0);
         end

      // R6: low pulse already past deadline
      run_slot(2, 1, 1, 7, 4, 12, 2, 0, 1'b0, 1'b0);

      // R9: timing inputs changed mid slot
      run_slot(1, 3, 1, 1, 4, 7, 2, 0, 1'b1, 1'b0);
      run_slot(2, 1, 1, 2, 5, 10, 3, 4, 1'b1, 1'b0);

      // R7: commands presented while busy
      run_slot(0, 1, 4, 1, 4, 8, 2, 0, 1'b0, 1'b1);
      run_slot(2, 1, 1, 1, 4, 12, 2, 8, 1'b0, 1'b1);

      repeat (4) @(negedge clk);
      check(line_oe == 1'b0, "R10", "oe when idle", int'(line_oe), 0);
      finish_run();
   end
endmodule